// File: doc/BRIEF.md
# DMA Channel Request Qualifier and Arbiter

This block sits at the front of a twelve-channel DMA engine. For every channel it decides whether a transfer request is live, and it then grants the bus to one requesting channel at a time. A channel raises its request either by itself (auto-request) or from an external request pin (external-request), according to a 4-bit request-source code. Only the four lowest channels have request pins. Each of those pins can be sensed on a level or on an edge, chosen per channel.

Requests are qualified at two levels. At the channel level, a channel enable must be set and the channel's done flag must be clear. At the group level, channels 0–5 share one group control set and channels 6–11 share another. Each group control set holds a master enable, an address-fault flag and a non-maskable-interrupt flag. The grant is one-hot. The owner keeps it either for as long as its request stays up (burst) or for a single transfer strobe (cycle-steal). The datapath that moves the data returns that one-cycle strobe.

Top module: `dmaq_top`

## Requirements
- R1: A channel whose source code is 4'b0100 requests with no external input. When no channel holds the grant, a permitted request is granted one clock edge after it appears.
- R2: On channels 0–3, source code 4'b0000 makes the channel request from its own request pin, `dreq[i]`.
- R3: A channel of index 4 or above never requests on code 4'b0000. Any code other than 4'b0000 and 4'b0100 never requests on any channel.
- R4: A channel requests only when its enable is 1, its done flag is 0, its group master enable is 1, and its group fault and NMI flags are both 0.
- R5: Channels 0–5 use group bit 0 of `grp_men`, `grp_fault` and `grp_nmi`. Channels 6–11 use bit 1.
- R6: Request pins pass through two synchronizing flops. The 2-bit sense field `ext_sense[2i+1:2i]` selects the mode: 00 = request while low, 10 = request while high, 01 = falling edge, 11 = rising edge. A level change driven on the pin is granted three clock edges later.
- R7: A detected edge is held pending. The pending edge clears on an `xfer_strobe` while the channel is granted, and also whenever the channel is not permitted. If a new edge arrives in the same cycle as a clearing strobe, the edge stays pending.
- R8: Among channels that request at the same time, the lowest index wins.
- R9: In burst mode, which is sampled from `burst_mode` when the grant is issued, the owner keeps the grant while its request stays up and `bus_hold` is 1. When the request drops, the grant goes to zero for one cycle before the block arbitrates again.
- R10: In cycle-steal mode, `bus_hold` is 0. A strobe during the grant releases the grant at the next edge, and the block arbitrates again one cycle later.
- R11: After reset, `grant` and `bus_hold` are 0.
- R12: At most one bit of `grant` is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ch_src | input | 48 | Request-source code per channel, 4 bits per channel, channel i at [4i+3:4i] |
| ch_en | input | 12 | Channel enable |
| ch_done | input | 12 | Channel done flag (blocks requests) |
| grp_men | input | 2 | Group master enable (bit 0: channels 0–5, bit 1: channels 6–11) |
| grp_fault | input | 2 | Group address-fault flag |
| grp_nmi | input | 2 | Group NMI flag |
| ext_sense | input | 8 | Sense mode per request pin, 2 bits per pin |
| dreq | input | 4 | Asynchronous request pins for channels 0–3 |
| burst_mode | input | 1 | 1 = burst, 0 = cycle-steal, sampled at grant |
| xfer_strobe | input | 1 | One-cycle transfer-done strobe from the datapath |
| grant | output | 12 | One-hot channel grant |
| bus_hold | output | 1 | Grant is held in burst mode |

## Verification
The collision that matters is between the cycle-steal strobe, which consumes the owner's pending edge and releases the grant, and a new edge on the same pin, which tries to set that pending bit in the same cycle. The bench provokes it directly. It pulses the pin low and then high again so that the second rising edge reaches the detector exactly on the strobe's clock edge. It then expects one idle cycle followed by a fresh grant to the same channel. A second strobe must then leave the channel silent. Random phases keep strobes, pin flips and grants overlapping, and a cycle-level bench model judges every cycle.

// File: rtl/dmaq_pkg.sv
package dmaq_pkg;

  localparam int unsigned SRC_W = 4;

  // request-source codes decoded by every channel
  localparam logic [SRC_W-1:0] SRC_EXT  = 4'b0000;
  localparam logic [SRC_W-1:0] SRC_AUTO = 4'b0100;

  // per-pin sense field: bit0 = edge mode, bit1 = high/rising polarity
  typedef enum logic [1:0] {
    SNS_LOW  = 2'b00,
    SNS_FALL = 2'b01,
    SNS_HIGH = 2'b10,
    SNS_RISE = 2'b11
  } sense_e;

endpackage

// File: rtl/dmaq_sync.sv
module dmaq_sync #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out
);

  logic [W-1:0] stg1_q;
  logic [W-1:0] stg2_q;

  generate
    for (genvar b = 0; b < W; b++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          stg1_q[b] <= 1'b0;
          stg2_q[b] <= 1'b0;
        end else begin
          stg1_q[b] <= async_in[b];
          stg2_q[b] <= stg1_q[b];
        end
      end
    end
  endgenerate

  assign sync_out = stg2_q;

endmodule

// File: rtl/dmaq_detect.sv
module dmaq_detect #(
  parameter int unsigned N_EXT = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_EXT-1:0]   pin_sync,
  input  logic [2*N_EXT-1:0] sense,
  input  logic [N_EXT-1:0]   permit,
  input  logic [N_EXT-1:0]   consume,
  output logic [N_EXT-1:0]   hit
);

  logic [N_EXT-1:0] prev_q;
  logic [N_EXT-1:0] pend_q;
  logic [N_EXT-1:0] pend_d;
  logic [N_EXT-1:0] edge_now;
  logic [N_EXT-1:0] lvl_now;

  generate
    for (genvar i = 0; i < N_EXT; i++) begin : g_pin
      logic is_edge;
      logic pol_hi;
      assign is_edge = sense[2*i];
      assign pol_hi  = sense[2*i+1];

      always_comb begin
        if (is_edge) begin
          edge_now[i] = pol_hi ? (pin_sync[i] & ~prev_q[i])
                               : (~pin_sync[i] & prev_q[i]);
        end else begin
          edge_now[i] = 1'b0;
        end
        lvl_now[i] = pol_hi ? pin_sync[i] : ~pin_sync[i];
        pend_d[i]  = permit[i] & (edge_now[i] | (pend_q[i] & ~consume[i]));
        hit[i]     = is_edge ? pend_q[i] : lvl_now[i];
      end

      // R7: a consumed pending edge is gone unless a new edge arrives
      assert_edge_consumed_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q[i] && consume[i] && !edge_now[i]) |=> !pend_q[i]);

      // R7: a fresh edge on a permitted channel is always captured
      assert_edge_captured_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_now[i] && permit[i]) |=> pend_q[i]);
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      pend_q <= '0;
    end else begin
      prev_q <= pin_sync;
      pend_q <= pend_d;
    end
  end

endmodule

// File: rtl/dmaq_arb.sv
module dmaq_arb #(
  parameter int unsigned N_CH = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N_CH-1:0] req,
  input  logic            burst_mode,
  input  logic            xfer_strobe,
  output logic [N_CH-1:0] grant,
  output logic            bus_hold
);

  logic [N_CH-1:0] grant_q;
  logic [N_CH-1:0] grant_d;
  logic            mode_q;
  logic            mode_d;
  logic [N_CH-1:0] pick;
  logic            owner_live;
  logic            busy;

  assign busy       = |grant_q;
  assign owner_live = |(grant_q & req);

  // fixed priority: lowest index wins
  always_comb begin
    pick = '0;
    for (int i = N_CH - 1; i >= 0; i--) begin
      if (req[i]) begin
        pick    = '0;
        pick[i] = 1'b1;
      end
    end
  end

  always_comb begin
    grant_d = grant_q;
    mode_d  = mode_q;
    if (busy) begin
      if (!owner_live) begin
        grant_d = '0;
      end else if (!mode_q && xfer_strobe) begin
        grant_d = '0;
      end
    end else begin
      grant_d = pick;
      mode_d  = burst_mode;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grant_q <= '0;
      mode_q  <= 1'b0;
    end else begin
      grant_q <= grant_d;
      mode_q  <= mode_d;
    end
  end

  assign grant    = grant_q;
  assign bus_hold = busy & mode_q;

  assert_grant_onehot_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_q));

  assert_idle_grants_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && (|req)) |=> (|grant_q));

  assert_burst_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && mode_q && owner_live) |=> $stable(grant_q));

  assert_steal_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !mode_q && xfer_strobe) |=> (grant_q == '0));

endmodule

// File: rtl/dmaq_top.sv
module dmaq_top
  import dmaq_pkg::*;
#(
  parameter int unsigned N_CH      = 12,
  parameter int unsigned N_EXT     = 4,
  parameter int unsigned GRP_SPLIT = 6
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [N_CH*SRC_W-1:0] ch_src,
  input  logic [N_CH-1:0]       ch_en,
  input  logic [N_CH-1:0]       ch_done,
  input  logic [1:0]            grp_men,
  input  logic [1:0]            grp_fault,
  input  logic [1:0]            grp_nmi,
  input  logic [2*N_EXT-1:0]    ext_sense,
  input  logic [N_EXT-1:0]      dreq,
  input  logic                  burst_mode,
  input  logic                  xfer_strobe,
  output logic [N_CH-1:0]       grant,
  output logic                  bus_hold
);

  localparam int unsigned N_GRP = 2;

  logic [N_GRP-1:0] grp_ok;
  logic [N_CH-1:0]  permit;
  logic [N_CH-1:0]  req;
  logic [N_EXT-1:0] pin_sync;
  logic [N_EXT-1:0] ext_hit;
  logic [N_EXT-1:0] consume;

  assign grp_ok = grp_men & ~grp_fault & ~grp_nmi;

  dmaq_sync #(.W(N_EXT)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (dreq),
    .sync_out (pin_sync)
  );

  assign consume = {N_EXT{xfer_strobe}} & grant[N_EXT-1:0];

  dmaq_detect #(.N_EXT(N_EXT)) u_detect (
    .clk      (clk),
    .rst_n    (rst_n),
    .pin_sync (pin_sync),
    .sense    (ext_sense),
    .permit   (permit[N_EXT-1:0]),
    .consume  (consume),
    .hit      (ext_hit)
  );

  generate
    for (genvar i = 0; i < N_CH; i++) begin : g_ch
      localparam int unsigned GSEL = (i < GRP_SPLIT) ? 0 : 1;
      logic [SRC_W-1:0] src;
      logic             auto_req;
      logic             pin_req;

      assign src       = ch_src[SRC_W*i +: SRC_W];
      assign permit[i] = ch_en[i] & ~ch_done[i] & grp_ok[GSEL];
      assign auto_req  = (src == SRC_AUTO);

      if (i < N_EXT) begin : g_pin
        assign pin_req = (src == SRC_EXT) & ext_hit[i];
      end else begin : g_nopin
        assign pin_req = 1'b0;
        // R3: channels without a pin are granted only after an auto code
        assert_nopin_silent_R3: assert property (@(posedge clk) disable iff (!rst_n)
          grant[i] |-> $past(ch_src[SRC_W*i +: SRC_W] == SRC_AUTO));
      end

      assign req[i] = permit[i] & (auto_req | pin_req);
    end
  endgenerate

  dmaq_arb #(.N_CH(N_CH)) u_arb (
    .clk         (clk),
    .rst_n       (rst_n),
    .req         (req),
    .burst_mode  (burst_mode),
    .xfer_strobe (xfer_strobe),
    .grant       (grant),
    .bus_hold    (bus_hold)
  );

  // R4: a granted channel was permitted on the preceding edge
  assert_grant_permitted_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (|grant) |-> (|(grant & $past(permit))));

endmodule

// File: tb/dmaq_top_tb.sv
`timescale 1ns/1ps
module dmaq_top_tb;
  import dmaq_pkg::*;

  localparam int NC = 12;
  localparam int NE = 4;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [NC*4-1:0] ch_src;
  logic [NC-1:0]  ch_en, ch_done;
  logic [1:0]     grp_men, grp_fault, grp_nmi;
  logic [2*NE-1:0] ext_sense;
  logic [NE-1:0]  dreq;
  logic           burst_mode, xfer_strobe;
  logic [NC-1:0]  grant;
  logic           bus_hold;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  dmaq_top u_dut (
    .clk(clk), .rst_n(rst_n), .ch_src(ch_src), .ch_en(ch_en), .ch_done(ch_done),
    .grp_men(grp_men), .grp_fault(grp_fault), .grp_nmi(grp_nmi),
    .ext_sense(ext_sense), .dreq(dreq), .burst_mode(burst_mode),
    .xfer_strobe(xfer_strobe), .grant(grant), .bus_hold(bus_hold)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- reference model from the requirements ----------------
  logic [NE-1:0] m_s1, m_s2, m_s3, m_ep;
  logic [NC-1:0] m_grant;
  logic          m_mode;

  function automatic logic permit_f(input int i);
    int g;
    g = (i < 6) ? 0 : 1;
    return ch_en[i] & ~ch_done[i] & grp_men[g] & ~grp_fault[g] & ~grp_nmi[g];
  endfunction

  always @(posedge clk or negedge rst_n) begin : mdl
    logic [NC-1:0] rq, nxt, pk;
    logic [NE-1:0] nep;
    logic [1:0] sn;
    logic cur, prv, edg, lvl, hit;
    if (!rst_n) begin
      m_s1 <= '0; m_s2 <= '0; m_s3 <= '0; m_ep <= '0;
      m_grant <= '0; m_mode <= 1'b0;
    end else begin
      rq = '0; nep = '0;
      for (int i = 0; i < NC; i++) begin
        hit = 1'b0;
        if (i < NE) begin
          sn  = ext_sense[2*i +: 2];
          cur = m_s2[i]; prv = m_s3[i];
          edg = sn[0] & (sn[1] ? (cur & ~prv) : (~cur & prv));
          lvl = sn[1] ? cur : ~cur;
          hit = sn[0] ? m_ep[i] : lvl;
          nep[i] = permit_f(i) & (edg | (m_ep[i] & ~(xfer_strobe & m_grant[i])));
        end
        rq[i] = permit_f(i) & ((ch_src[4*i +: 4] == SRC_AUTO) |
                ((i < NE) & (ch_src[4*i +: 4] == SRC_EXT) & hit));
      end
      pk = '0;
      for (int i = NC - 1; i >= 0; i--) if (rq[i]) begin pk = '0; pk[i] = 1'b1; end
      nxt = m_grant;
      if (|m_grant) begin
        if (!(|(m_grant & rq))) nxt = '0;
        else if (!m_mode && xfer_strobe) nxt = '0;
      end else begin
        nxt = pk;
        m_mode <= burst_mode;
      end
      m_grant <= nxt;
      m_ep <= nep;
      m_s1 <= dreq; m_s2 <= m_s1; m_s3 <= m_s2;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk(grant == m_grant, "R1/R8 model grant", {20'd0, grant}, {20'd0, m_grant});
      chk(bus_hold == ((|m_grant) & m_mode), "R9/R10 model bus_hold",
          {31'd0, bus_hold}, {31'd0, (|m_grant) & m_mode});
      chk($countones(grant) <= 1, "R12 onehot", {20'd0, grant}, 32'd0);
    end
  end

  // ---------------- helpers ----------------
  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_src(input int ch, input logic [3:0] code);
    ch_src[4*ch +: 4] = code;
  endtask

  task automatic quiet();
    ch_src = {NC{4'hF}};
    ch_en = '1; ch_done = '0;
    grp_men = 2'b11; grp_fault = '0; grp_nmi = '0;
    ext_sense = {NE{SNS_HIGH}};
    dreq = '0; burst_mode = 1'b1; xfer_strobe = 1'b0;
  endtask

  function automatic logic [NC-1:0] oh(input int i);
    logic [NC-1:0] v;
    v = '0; v[i] = 1'b1;
    return v;
  endfunction

  task automatic rand_cfg();
    for (int i = 0; i < NC; i++) begin
      int r;
      r = $urandom % 8;
      if (r < 3) set_src(i, SRC_AUTO);
      else if (r < 5) set_src(i, SRC_EXT);
      else set_src(i, {1'b1, 3'(r)});
      ch_en[i]   = ($urandom % 8) != 0;
      ch_done[i] = ($urandom % 10) == 0;
    end
    for (int g = 0; g < 2; g++) begin
      grp_men[g]   = ($urandom % 6) != 0;
      grp_fault[g] = ($urandom % 12) == 0;
      grp_nmi[g]   = ($urandom % 12) == 0;
    end
    ext_sense  = 8'($urandom);
    burst_mode = 1'($urandom);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog R11 actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  initial begin
    void'($urandom(32'h5EED_0042));
    quiet();
    step(3);
    chk(grant == '0 && bus_hold == 1'b0, "R11 reset state", {19'd0, bus_hold, grant}, 32'd0);
    rst_n = 1'b1;
    step(2);
    chk(grant == '0, "R11 idle after reset", {20'd0, grant}, 32'd0);

    // R1 / R9: auto request, burst hold
    set_src(5, SRC_AUTO);
    step(1);
    chk(grant == oh(5), "R1 auto grant", {20'd0, grant}, {20'd0, oh(5)});
    chk(bus_hold == 1'b1, "R9 bus_hold burst", {31'd0, bus_hold}, 32'd1);
    set_src(2, SRC_AUTO);
    step(2);
    chk(grant == oh(5), "R9 burst keeps owner", {20'd0, grant}, {20'd0, oh(5)});
    set_src(5, 4'hF);
    step(1);
    chk(grant == '0, "R9 release gap", {20'd0, grant}, 32'd0);
    step(1);
    chk(grant == oh(2), "R9 rearbitrate", {20'd0, grant}, {20'd0, oh(2)});
    set_src(2, 4'hF);
    step(3);

    // R8: priority
    set_src(9, SRC_AUTO); set_src(3, SRC_AUTO);
    step(1);
    chk(grant == oh(3), "R8 lowest index wins", {20'd0, grant}, {20'd0, oh(3)});
    set_src(9, 4'hF); set_src(3, 4'hF);
    step(3);

    // R4 / R5: qualification and group mapping
    set_src(7, SRC_AUTO);
    step(2);
    chk(grant == oh(7), "R4 permitted ch7", {20'd0, grant}, {20'd0, oh(7)});
    grp_fault[1] = 1'b1;
    step(2);
    chk(grant == '0, "R4 fault blocks group1", {20'd0, grant}, 32'd0);
    grp_fault = 2'b01;
    step(2);
    chk(grant == oh(7), "R5 group0 fault spares ch7", {20'd0, grant}, {20'd0, oh(7)});
    grp_fault = '0; grp_nmi[1] = 1'b1;
    step(2);
    chk(grant == '0, "R4 nmi blocks", {20'd0, grant}, 32'd0);
    grp_nmi = '0; grp_men[1] = 1'b0;
    step(2);
    chk(grant == '0, "R4 master enable", {20'd0, grant}, 32'd0);
    grp_men = 2'b11; ch_done[7] = 1'b1;
    step(2);
    chk(grant == '0, "R4 done flag", {20'd0, grant}, 32'd0);
    ch_done[7] = 1'b0; ch_en[7] = 1'b0;
    step(2);
    chk(grant == '0, "R4 channel enable", {20'd0, grant}, 32'd0);
    ch_en[7] = 1'b1; set_src(7, 4'hF);
    step(3);

    // R3: no pin above channel 3, other codes silent
    set_src(6, SRC_EXT); set_src(1, 4'b0010);
    dreq = '1;
    step(5);
    chk(grant == '0, "R3 silent codes", {20'd0, grant}, 32'd0);
    dreq = '0; set_src(6, 4'hF); set_src(1, 4'hF);
    step(4);

    // R2 / R6: level sensing through the synchronizer
    set_src(1, SRC_EXT); ext_sense[3:2] = SNS_HIGH;
    step(2);
    dreq[1] = 1'b1;
    step(2);
    chk(grant == '0, "R6 sync latency", {20'd0, grant}, 32'd0);
    step(1);
    chk(grant == oh(1), "R2 pin grant", {20'd0, grant}, {20'd0, oh(1)});
    ext_sense[3:2] = SNS_LOW;
    step(2);
    chk(grant == '0, "R6 low-level sense", {20'd0, grant}, 32'd0);
    set_src(1, 4'hF); dreq = '0; ext_sense[3:2] = SNS_HIGH;
    step(4);

    // R7 / R10: edge consumed by strobe, new edge in the same cycle survives
    burst_mode = 1'b0;
    set_src(0, SRC_EXT); ext_sense[1:0] = SNS_RISE;
    step(3);
    dreq[0] = 1'b1;
    step(1); dreq[0] = 1'b0;
    step(1); dreq[0] = 1'b1;
    step(1);
    chk(grant == '0, "R7 edge latency", {20'd0, grant}, 32'd0);
    step(1);
    chk(grant == oh(0), "R7 edge grant", {20'd0, grant}, {20'd0, oh(0)});
    chk(bus_hold == 1'b0, "R10 no hold in steal", {31'd0, bus_hold}, 32'd0);
    xfer_strobe = 1'b1;
    step(1);
    xfer_strobe = 1'b0;
    chk(grant == '0, "R10 strobe releases", {20'd0, grant}, 32'd0);
    step(1);
    chk(grant == oh(0), "R7 collided edge kept", {20'd0, grant}, {20'd0, oh(0)});
    xfer_strobe = 1'b1;
    step(1);
    xfer_strobe = 1'b0;
    step(2);
    chk(grant == '0, "R7 edge consumed", {20'd0, grant}, 32'd0);
    quiet();
    step(4);

    // random phase, judged by the model every cycle
    for (int blk = 0; blk < 250; blk++) begin
      rand_cfg();
      for (int c = 0; c < 16; c++) begin
        for (int p = 0; p < NE; p++) if (($urandom % 6) == 0) dreq[p] = ~dreq[p];
        xfer_strobe = ($urandom % 3) == 0;
        step(1);
      end
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule